// File: doc/BRIEF.md
# Wishbone Word-to-Byte Register Bridge

This block puts a bank of byte-wide configuration registers behind a 32-bit Wishbone slave. The registers are shared with a second, byte-serial access port. That port stands in for a serial shifter that sits outside this block. A Wishbone access that falls inside the block's 256-byte address window is served by a small sequencer. The sequencer walks the four byte addresses of the addressed word one after another. Each byte address passes through a decoder that either selects one register or reports a miss. The bus cycle is stalled while the sequencer runs. The acknowledge is raised only after the fourth byte has been handled.

The serial port issues single-byte reads and writes by offset. When it wants the register file in the same cycle as the sequencer, the serial port is served first and the sequencer retries on the next cycle. Byte selects on the Wishbone side gate which bytes a write changes. Reads always gather all four bytes, little-endian. Offsets beyond the last register behave as empty space: they read as zero and drop writes, and the bus access still completes.

Top module: `wb_byte_bridge`

## Requirements
- R1: Only an access whose address bits 31:8 equal 0x260000 is served. An access outside that window is never acknowledged and changes no register.
- R2: An in-window access is acknowledged 5 clock cycles after the first clock edge that samples CYC and STB high, when there is no serial contention. Exactly four byte operations happen between the start and the acknowledge.
- R3: On a write, bit n of the byte select enables byte lane n. A lane whose bit is clear leaves its register unchanged.
- R4: The word address is the bus address with bits 1:0 cleared. The byte at word offset n appears in data bits 8n+7:8n, for both reads and writes.
- R5: Byte offsets 14 and above are unmapped. They read as zero on either port, ignore writes, and Wishbone accesses to them are still acknowledged on time.
- R6: A serial request wins the register file over the sequencer in the same cycle. Each such collision delays the Wishbone acknowledge by one cycle, and the serial write takes effect.
- R7: Both ports reach the same registers. A byte written by one port is read back by the other. Serial read data appears on the serial read output the cycle after the request.
- R8: During and after reset the acknowledge is low, and register n holds 0xA5 XOR n.
- R9: The acknowledge is high for exactly one cycle, and a following access can start right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | 32 | Wishbone byte address |
| wb_sel_i | input | 4 | Wishbone byte selects, bit n for lane n |
| wb_dat_i | input | 32 | Wishbone write data |
| wb_dat_o | output | 32 | Wishbone read data, valid with the acknowledge |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| ser_req_i | input | 1 | Serial-port byte request |
| ser_we_i | input | 1 | Serial-port write, otherwise read |
| ser_addr_i | input | 8 | Serial-port byte offset |
| ser_wdata_i | input | 8 | Serial-port write byte |
| ser_rdata_o | output | 8 | Serial-port read byte, one cycle after the request |

## Verification
The word path is tried with several patterns. A full-select write to a word of fully mapped registers shows the lane-to-bit ordering. A sparse select pattern on another word tells lane gating apart from whole-word writes. A read with nonzero low address bits confirms that those bits are dropped. A word straddling the end of the map separates mapped lanes from empty ones within one access, and a word wholly past the map shows that such accesses still finish on time. Out-of-window addresses, including one just past the window, check that no acknowledge comes and no register changes. A serial write timed to collide with the sequencer's first lane shows both the one-cycle delay and, through a later lane of the same read, that the serial write took effect.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam int LANES = 4;

  // Reset value of register number idx.
  function automatic logic [7:0] reg_default(input int unsigned idx);
    reg_default = 8'hA5 ^ 8'(idx);
  endfunction

endpackage

// File: rtl/wbb_decode.sv
module wbb_decode #(
  parameter int OFF_W    = 8,
  parameter int NUM_REGS = 14,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [OFF_W-1:0] off,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    hit = (32'(off) < NUM_REGS);
    idx = IDX_W'(off);
  end

endmodule

// File: rtl/wbb_regfile.sv
module wbb_regfile
  import wbb_pkg::*;
#(
  parameter int NUM_REGS = 14,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [NUM_REGS*8-1:0] flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic       load;
    logic [7:0] q;
    assign load = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= reg_default(g);
      else if (load) q <= wr_data;
    end
    assign flat[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = flat[i*8 +: 8];
    end
  end

endmodule

// File: rtl/wbb_seq.sv
module wbb_seq
  import wbb_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFF_W-3:0] word_off,
  input  logic             we,
  input  logic [3:0]       sel,
  input  logic [31:0]      wdat,
  output logic             ack,
  output logic [31:0]      rdat,
  output logic             req,
  input  logic             gnt,
  output logic [OFF_W-1:0] acc_off,
  output logic             acc_we,
  output logic [7:0]       acc_wdata,
  input  logic [7:0]       acc_rdata
);

  seq_state_e       state_q, state_d;
  logic [1:0]       lane_q, lane_d;
  logic             capture_en;
  logic             rbuf_en;
  logic [OFF_W-3:0] base_q;
  logic             we_q;
  logic [3:0]       sel_q;
  logic [31:0]      wdat_q;
  logic [31:0]      rbuf_q, rbuf_d;

  // next state
  always_comb begin
    state_d    = state_q;
    lane_d     = lane_q;
    capture_en = 1'b0;
    rbuf_en    = 1'b0;
    rbuf_d     = rbuf_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d    = SEQ_RUN;
          lane_d     = 2'd0;
          capture_en = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (gnt) begin
          rbuf_en                 = 1'b1;
          rbuf_d[8*lane_q +: 8]   = acc_rdata;
          lane_d                  = lane_q + 2'd1;
          if (lane_q == 2'd3) state_d = SEQ_DONE;
        end
      end
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      lane_q  <= 2'd0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      we_q   <= 1'b0;
      sel_q  <= 4'h0;
      wdat_q <= 32'h0;
    end else if (capture_en) begin
      base_q <= word_off;
      we_q   <= we;
      sel_q  <= sel;
      wdat_q <= wdat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rbuf_q <= 32'h0;
    else if (rbuf_en) rbuf_q <= rbuf_d;
  end

  assign req       = (state_q == SEQ_RUN);
  assign ack       = (state_q == SEQ_DONE);
  assign rdat      = rbuf_q;
  assign acc_off   = {base_q, lane_q};
  assign acc_we    = we_q & sel_q[lane_q];
  assign acc_wdata = wdat_q[8*lane_q +: 8];

endmodule

// File: rtl/wb_byte_bridge.sv
module wb_byte_bridge
  import wbb_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [31:0]     WIN_BASE = 32'h2600_0000,
  parameter int              OFF_W    = 8,
  parameter int              NUM_REGS = 14,
  localparam int             IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [3:0]        wb_sel_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  input  logic              ser_req_i,
  input  logic              ser_we_i,
  input  logic [OFF_W-1:0]  ser_addr_i,
  input  logic [7:0]        ser_wdata_i,
  output logic [7:0]        ser_rdata_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // window decode
  logic in_win;
  logic start;
  logic [1:0] unused_adr_lsb;
  assign in_win         = (wb_adr_i[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]);
  assign start          = wb_cyc_i & wb_stb_i & in_win;
  assign unused_adr_lsb = wb_adr_i[1:0];

  // sequencer
  logic             seq_req;
  logic             seq_gnt;
  logic [OFF_W-1:0] seq_off;
  logic             seq_we;
  logic [7:0]       seq_wdata;
  logic [7:0]       rd_byte;

  wbb_seq #(.OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .word_off  (wb_adr_i[OFF_W-1:2]),
    .we        (wb_we_i),
    .sel       (wb_sel_i),
    .wdat      (wb_dat_i),
    .ack       (wb_ack_o),
    .rdat      (wb_dat_o),
    .req       (seq_req),
    .gnt       (seq_gnt),
    .acc_off   (seq_off),
    .acc_we    (seq_we),
    .acc_wdata (seq_wdata),
    .acc_rdata (rd_byte)
  );

  // arbitration: serial port has priority
  logic [OFF_W-1:0] acc_off;
  logic             acc_wr;
  logic [7:0]       acc_wdata;
  always_comb begin
    seq_gnt = seq_req & ~ser_req_i;
    if (ser_req_i) begin
      acc_off   = ser_addr_i;
      acc_wr    = ser_we_i;
      acc_wdata = ser_wdata_i;
    end else begin
      acc_off   = seq_off;
      acc_wr    = seq_req & seq_we;
      acc_wdata = seq_wdata;
    end
  end

  // decode and storage
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rf_rdata;

  wbb_decode #(.OFF_W(OFF_W), .NUM_REGS(NUM_REGS)) u_dec (
    .off (acc_off),
    .hit (hit),
    .idx (idx)
  );

  wbb_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (acc_wr & hit),
    .wr_idx  (idx),
    .wr_data (acc_wdata),
    .rd_idx  (idx),
    .rd_data (rf_rdata)
  );

  assign rd_byte = hit ? rf_rdata : 8'h00;

  // serial read return register
  logic ser_rd_en;
  assign ser_rd_en = ser_req_i & ~ser_we_i;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       ser_rdata_o <= 8'h00;
    else if (ser_rd_en) ser_rdata_o <= rd_byte;
  end

endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
  parameter int OFF_W    = 8,
  parameter int NUM_REGS = 14
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             wb_ack_o,
  input logic             in_win,
  input logic             seq_gnt,
  input logic             ser_req_i,
  input logic             ser_we_i,
  input logic [OFF_W-1:0] ser_addr_i,
  input logic [7:0]       ser_rdata_o
);

  logic [2:0] lane_cnt;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      lane_cnt <= 3'd0;
    else if (wb_ack_o) lane_cnt <= 3'd0;
    else if (seq_gnt)  lane_cnt <= lane_cnt + 3'd1;
  end

  AST_ACK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n_s) wb_ack_o |-> in_win);  // R1
  AST_FOUR_LANES: assert property (@(posedge clk) disable iff (!rst_n_s) wb_ack_o |-> (lane_cnt == 3'd4));  // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s) (ser_req_i && !ser_we_i && (32'(ser_addr_i) >= NUM_REGS)) |=> (ser_rdata_o == 8'h00));  // R5
  AST_SERIAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n_s) ser_req_i |-> !seq_gnt);  // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s) wb_ack_o |=> !wb_ack_o);  // R9

  always @(posedge clk) begin
    if (!rst_n_s) begin
      AST_RESET_NO_ACK: assert (!wb_ack_o);  // R8
    end
  end

endmodule

bind wb_byte_bridge wbb_checker #(.OFF_W(OFF_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .wb_ack_o    (wb_ack_o),
  .in_win      (in_win),
  .seq_gnt     (seq_gnt),
  .ser_req_i   (ser_req_i),
  .ser_we_i    (ser_we_i),
  .ser_addr_i  (ser_addr_i),
  .ser_rdata_o (ser_rdata_o)
);

// File: tb/wb_byte_bridge_test.sv
`timescale 1ns/1ps
module wb_byte_bridge_test;

  localparam int NREG = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wb_cyc, wb_stb, wb_we;
  logic [31:0] wb_adr, wb_dat_w, wb_dat_r;
  logic [3:0]  wb_sel;
  logic        wb_ack;
  logic        ser_req, ser_we;
  logic [7:0]  ser_addr, ser_wdata, ser_rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [256];

  always #4 clk = ~clk;

  wb_byte_bridge uut (
    .clk (clk), .rst_n (rst_n),
    .wb_cyc_i (wb_cyc), .wb_stb_i (wb_stb), .wb_we_i (wb_we),
    .wb_adr_i (wb_adr), .wb_sel_i (wb_sel), .wb_dat_i (wb_dat_w),
    .wb_dat_o (wb_dat_r), .wb_ack_o (wb_ack),
    .ser_req_i (ser_req), .ser_we_i (ser_we), .ser_addr_i (ser_addr),
    .ser_wdata_i (ser_wdata), .ser_rdata_o (ser_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] adr);
    logic [31:0] w = 32'h0;
    for (int i = 0; i < 4; i++) begin
      int b = int'({adr[7:2], 2'b00}) + i;
      if (b < NREG) w[8*i +: 8] = mdl[b];
    end
    return w;
  endfunction

  task automatic wb_xfer(input logic [31:0] adr, input logic we, input logic [3:0] sel,
                         input logic [31:0] dat, output logic [31:0] rd, output int lat);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_adr = adr; wb_we = we; wb_sel = sel; wb_dat_w = dat;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!wb_ack && lat < 40);
    rd = wb_dat_r;
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    if (we && adr[31:8] == 24'h260000) begin
      for (int i = 0; i < 4; i++) begin
        int b = int'({adr[7:2], 2'b00}) + i;
        if (sel[i] && b < NREG) mdl[b] = dat[8*i +: 8];
      end
    end
    @(negedge clk);
    check(!wb_ack, "R9 ack single cycle", {31'd0, wb_ack}, 32'd0);
  endtask

  task automatic ser_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ser_req = 1; ser_we = 1; ser_addr = a; ser_wdata = d;
    @(negedge clk);
    ser_req = 0; ser_we = 0;
    if (a < NREG) mdl[a] = d;
  endtask

  task automatic ser_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    ser_req = 1; ser_we = 0; ser_addr = a;
    @(negedge clk);
    ser_req = 0;
    d = ser_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    int lat;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!wb_ack, "R8 ack low in reset", {31'd0, wb_ack}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int w = 0; w < 16; w += 4) begin
      wb_xfer(32'h2600_0000 + w, 0, 4'h0, 32'h0, rd, lat);
      check(rd == exp_word(32'h2600_0000 + w), "R8 default values", rd, exp_word(32'h2600_0000 + w));
    end
  endtask

  task automatic t_full_write;
    logic [31:0] rd;
    int lat;
    wb_xfer(32'h2600_0004, 1, 4'hF, 32'h1122_3344, rd, lat);
    check(lat == 5, "R2 write latency", lat, 5);
    wb_xfer(32'h2600_0004, 0, 4'hF, 32'h0, rd, lat);
    check(lat == 5, "R2 read latency", lat, 5);
    check(rd == 32'h1122_3344, "R4 little-endian read back", rd, 32'h1122_3344);
  endtask

  task automatic t_lane_gate;
    logic [31:0] rd;
    int lat;
    wb_xfer(32'h2600_0000, 1, 4'b0101, 32'hDEAD_BEEF, rd, lat);
    wb_xfer(32'h2600_0000, 0, 4'h0, 32'h0, rd, lat);
    check(rd == exp_word(32'h2600_0000), "R3 byte select gating", rd, exp_word(32'h2600_0000));
    check(rd[15:8] == 8'hA4, "R3 unselected lane kept", rd[15:8], 8'hA4);
    wb_xfer(32'h2600_0002, 0, 4'h0, 32'h0, rd, lat);
    check(rd == exp_word(32'h2600_0000), "R4 low address bits ignored", rd, exp_word(32'h2600_0000));
  endtask

  task automatic t_unmapped;
    logic [31:0] rd;
    logic [7:0] b;
    int lat;
    wb_xfer(32'h2600_0010, 1, 4'hF, 32'hFFFF_FFFF, rd, lat);
    check(lat == 5, "R5 unmapped write acknowledged", lat, 5);
    wb_xfer(32'h2600_0010, 0, 4'hF, 32'h0, rd, lat);
    check(rd == 32'h0, "R5 unmapped reads zero", rd, 32'h0);
    wb_xfer(32'h2600_000C, 1, 4'hF, 32'h7777_6655, rd, lat);
    wb_xfer(32'h2600_000C, 0, 4'hF, 32'h0, rd, lat);
    check(rd == 32'h0000_6655, "R5 straddling word", rd, 32'h0000_6655);
    ser_wr(8'h20, 8'h77);
    ser_rd(8'h20, b);
    check(b == 8'h00, "R5 serial unmapped zero", b, 8'h00);
  endtask

  task automatic t_window;
    logic [31:0] rd;
    int lat;
    int acks = 0;
    logic [31:0] bad [2] = '{32'h2700_0004, 32'h2600_0104};
    foreach (bad[k]) begin
      @(negedge clk);
      wb_cyc = 1; wb_stb = 1; wb_adr = bad[k]; wb_we = 1; wb_sel = 4'hF; wb_dat_w = 32'hCAFE_F00D;
      repeat (12) begin
        @(negedge clk);
        if (wb_ack) acks++;
      end
      wb_cyc = 0; wb_stb = 0; wb_we = 0;
    end
    check(acks == 0, "R1 no ack outside window", acks, 0);
    wb_xfer(32'h2600_0004, 0, 4'hF, 32'h0, rd, lat);
    check(rd == exp_word(32'h2600_0004), "R1 registers untouched", rd, exp_word(32'h2600_0004));
  endtask

  task automatic t_shared;
    logic [31:0] rd;
    logic [7:0] b;
    int lat;
    ser_wr(8'd9, 8'h5C);
    wb_xfer(32'h2600_0008, 0, 4'hF, 32'h0, rd, lat);
    check(rd[15:8] == 8'h5C, "R7 serial write seen on bus", rd[15:8], 8'h5C);
    wb_xfer(32'h2600_0008, 1, 4'b1000, 32'h3C00_0000, rd, lat);
    ser_rd(8'd11, b);
    check(b == 8'h3C, "R7 bus write seen on serial", b, 8'h3C);
  endtask

  task automatic t_collide;
    logic [31:0] rd;
    int lat;
    fork
      wb_xfer(32'h2600_0008, 0, 4'hF, 32'h0, rd, lat);
      begin
        @(negedge clk);
        @(negedge clk);
        ser_req = 1; ser_we = 1; ser_addr = 8'd9; ser_wdata = 8'h81;
        @(negedge clk);
        ser_req = 0; ser_we = 0;
        mdl[9] = 8'h81;
      end
    join
    check(lat == 6, "R6 one-cycle stall on collision", lat, 6);
    check(rd[15:8] == 8'h81, "R6 serial write took effect", rd[15:8], 8'h81);
  endtask

  task automatic t_back_to_back;
    logic [31:0] rd;
    int lat;
    wb_xfer(32'h2600_0004, 1, 4'hF, 32'hA1B2_C3D4, rd, lat);
    wb_xfer(32'h2600_0004, 0, 4'hF, 32'h0, rd, lat);
    check(lat == 5, "R9 next access starts at once", lat, 5);
    check(rd == 32'hA1B2_C3D4, "R9 back-to-back data", rd, 32'hA1B2_C3D4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wb_cyc = 0; wb_stb = 0; wb_we = 0; wb_adr = 0; wb_sel = 0; wb_dat_w = 0;
    ser_req = 0; ser_we = 0; ser_addr = 0; ser_wdata = 0;
    for (int i = 0; i < 256; i++) mdl[i] = (i < NREG) ? (8'hA5 ^ 8'(i)) : 8'h00;
    t_reset();
    t_full_write();
    t_lane_gate();
    t_unmapped();
    t_window();
    t_shared();
    t_collide();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule